// File: doc/BRIEF.md
# Streaming Serial Register-Access Slave

This block is a serial slave that gives a host controller access to a chip's configuration registers. Each frame starts with a direction bit, then a 15-bit register address, then data bytes. After the first byte, chip select may stay low, and every further group of 8 clocks moves one more byte. The register address steps up or down on its own after each byte. The block drives a simple single-cycle strobe port toward an external register file. It holds only one register itself: the interface configuration byte at address zero. That byte selects bit order, streaming direction, 3-wire or 4-wire operation, and a self-clearing soft reset.

The serial pins are oversampled in the system clock domain. Each pin passes through a two-flop synchronizer, and rising and falling serial-clock edges are detected from the synchronized copy. A controller `spi_stream_fsm` moves through four named states:
- `ST_IDLE`: chip select is high, and the configuration is copied for the next frame.
- `ST_HDR`: the direction bit and address are shifted in.
- `ST_WR`: bytes are received and committed.
- `ST_RD`: bytes are fetched and shifted out.

Transitions:
- IDLE→HDR: chip select falls.
- HDR→WR or HDR→RD: on the 16th rising edge, chosen by the direction bit.
- Any state→IDLE: chip select rises.

Top module: `spi_stream_slave`

## Requirements
- R1: A frame carries a direction bit (0 = write, 1 = read), then 15 address bits, then 8-bit data bytes. Input bits are sampled on rising serial-clock edges. A completed write byte to a nonzero address raises `reg_wr_o` with that address on `reg_addr_o` and that byte on `reg_wdata_o`.
- R2: Address and data are shifted most significant bit first when configuration bit 6 is 0, and least significant bit first when it is 1. The direction bit always comes first. A configuration change takes effect from the next frame.
- R3: Each completed write byte gives exactly one `reg_wr_o` pulse, one clock cycle wide. `reg_wr_o` and `reg_rd_o` are never high together.
- R4: While chip select stays low, each further 8 bits is a transfer to the next sequential address.
- R5: Configuration bit 5 = 1 makes the streaming address ascend. Bit 5 = 0, the default, makes it descend.
- R6: Read data is driven on falling edges, starting with the falling edge after the 16th rising edge. With configuration bit 4 = 1 (4-wire), data appears on `sdo_o` and `sdio_oe_o` stays low. With bit 4 = 0 (3-wire), data appears on `sdio_out_o`, `sdio_oe_o` is high only in the read data phase, and `sdo_o` stays 0.
- R7: A read of address 0 returns the configuration byte. A read of any other address raises `reg_rd_o` for one cycle and takes `reg_rdata_i` in the following cycle.
- R8: Only configuration bits 6..4 are stored. Written bits 3..0 are ignored. Read bits 3, 2, 1 and 0 mirror bits 4, 5, 6 and 7.
- R9: Writing configuration bit 7 = 1 returns the configuration to 0x00 and pulses `soft_rst_o` for one cycle. Bit 7 reads back as 0.
- R10: Raising chip select in the middle of a byte discards that byte without a write, returns to idle and releases `sdio_oe_o`.
- R11: After reset the configuration is 0x00, and `sdio_oe_o`, `sdo_o`, `reg_wr_o` and `soft_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idle low |
| csn_i | input | 1 | Active-low chip select |
| sdio_in_i | input | 1 | Serial data in (shared pin input side in 3-wire mode) |
| sdio_out_o | output | 1 | Shared pin drive value in 3-wire read |
| sdio_oe_o | output | 1 | Shared pin output enable |
| sdo_o | output | 1 | Dedicated serial output in 4-wire mode |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_addr_o | output | 15 | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, valid the cycle after `reg_rd_o` |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |

## Verification
A wrong header count or bit-order decode shows at once: the first write strobe carries the wrong address or data, or read bits come back shifted by one position. A wrong address step shows on the second byte of any streamed frame. A stale output enable or a missed abort shows at the ports within a few system clocks after chip select rises. A wrong mirror or soft-reset path shows on the next read of address zero.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_WR   = 2'd2,
        ST_RD   = 2'd3
    } fsm_state_t;

    localparam int CFG_ADDR = 0;

    // Configuration byte bit positions (behavioural: host software relies on them)
    localparam int CFG_SOFT_BIT = 7;
    localparam int CFG_LSB_BIT  = 6;
    localparam int CFG_ASC_BIT  = 5;
    localparam int CFG_W4_BIT   = 4;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int           WIDTH   = 3,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    chain_q[s] <= pin_i;
                end else begin
                    chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_cfg_reg.sv
module spi_cfg_reg
    import spi_stream_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] cfg_byte,
    output logic       lsb_first,
    output logic       addr_asc,
    output logic       wire4,
    output logic       soft_rst
);

    logic lsb_q, asc_q, w4_q, soft_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lsb_q  <= 1'b0;
            asc_q  <= 1'b0;
            w4_q   <= 1'b0;
            soft_q <= 1'b0;
        end else begin
            soft_q <= 1'b0;
            if (wr_en) begin
                if (wdata[CFG_SOFT_BIT]) begin
                    lsb_q  <= 1'b0;
                    asc_q  <= 1'b0;
                    w4_q   <= 1'b0;
                    soft_q <= 1'b1;
                end else begin
                    lsb_q <= wdata[CFG_LSB_BIT];
                    asc_q <= wdata[CFG_ASC_BIT];
                    w4_q  <= wdata[CFG_W4_BIT];
                end
            end
        end
    end

    // Upper nibble holds the fields; lower nibble reflects them bit-reversed.
    assign cfg_byte  = {1'b0, lsb_q, asc_q, w4_q, w4_q, asc_q, lsb_q, 1'b0};
    assign lsb_first = lsb_q;
    assign addr_asc  = asc_q;
    assign wire4     = w4_q;
    assign soft_rst  = soft_q;

    AST_SOFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_q |=> !soft_q); // R9

    AST_SOFT_CLEARS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        soft_q |-> (!lsb_q && !asc_q && !w4_q)); // R9

endmodule

// File: rtl/spi_stream_fsm.sv
module spi_stream_fsm
    import spi_stream_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi,
    input  logic              cfg_lsb,
    input  logic              cfg_asc,
    input  logic              cfg_w4,
    input  logic [DATA_W-1:0] ld_byte,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              out_bit,
    output logic              drive,
    output logic              frame_w4
);

    localparam int HDR_W  = ADDR_W + 1;
    localparam int CNT_W  = $clog2(HDR_W + 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);

    fsm_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [HDR_W-1:0]  hdr_q, hdr_nx;
    logic [DATA_W-1:0] dat_q, dat_nx, tx_q, wdata_q;
    logic [ADDR_W-1:0] addr_q, hdr_addr, addr_step;
    logic              hdr_dir, hdr_done;
    logic              lsb_q, asc_q, w4_q;
    logic              wr_q, rd_q, adv_q, pend_q, bit_q, drv_q;

    // Shift direction depends on the frame's bit order.
    assign hdr_nx    = lsb_q ? {sdi, hdr_q[HDR_W-1:1]} : {hdr_q[HDR_W-2:0], sdi};
    assign dat_nx    = lsb_q ? {sdi, dat_q[DATA_W-1:1]} : {dat_q[DATA_W-2:0], sdi};
    assign hdr_dir   = lsb_q ? hdr_nx[0] : hdr_nx[HDR_W-1];
    assign hdr_addr  = lsb_q ? hdr_nx[HDR_W-1:1] : hdr_nx[ADDR_W-1:0];
    assign addr_step = asc_q ? addr_q + ADDR_W'(1) : addr_q - ADDR_W'(1);
    assign hdr_done  = (state_q == ST_HDR) && sclk_rise && (cnt_q == HDR_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_act) state_d = ST_HDR;
            ST_HDR: begin
                if (!cs_act)       state_d = ST_IDLE;
                else if (hdr_done) state_d = hdr_dir ? ST_RD : ST_WR;
            end
            ST_WR: if (!cs_act) state_d = ST_IDLE;
            ST_RD: if (!cs_act) state_d = ST_IDLE;
        endcase
    end

    // Datapath and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            hdr_q   <= '0;
            dat_q   <= '0;
            tx_q    <= '0;
            wdata_q <= '0;
            addr_q  <= '0;
            lsb_q   <= 1'b0;
            asc_q   <= 1'b0;
            w4_q    <= 1'b0;
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            adv_q   <= 1'b0;
            pend_q  <= 1'b0;
            bit_q   <= 1'b0;
            drv_q   <= 1'b0;
        end else begin
            wr_q   <= 1'b0;
            rd_q   <= 1'b0;
            adv_q  <= 1'b0;
            pend_q <= rd_q;
            if (state_q == ST_IDLE) begin
                lsb_q <= cfg_lsb;
                asc_q <= cfg_asc;
                w4_q  <= cfg_w4;
            end
            if (!cs_act) begin
                cnt_q <= '0;
                drv_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_HDR: begin
                        if (sclk_rise) begin
                            hdr_q <= hdr_nx;
                            if (cnt_q == HDR_LAST) begin
                                cnt_q  <= '0;
                                addr_q <= hdr_addr;
                                rd_q   <= hdr_dir;
                            end else begin
                                cnt_q <= cnt_q + CNT_W'(1);
                            end
                        end
                    end
                    ST_WR, ST_RD: begin
                        if (sclk_rise) begin
                            dat_q <= dat_nx;
                            if (cnt_q == BYTE_LAST) begin
                                cnt_q <= '0;
                                if (state_q == ST_WR) begin
                                    wr_q    <= 1'b1;
                                    wdata_q <= dat_nx;
                                end else begin
                                    adv_q <= 1'b1;
                                end
                            end else begin
                                cnt_q <= cnt_q + CNT_W'(1);
                            end
                        end
                    end
                    ST_IDLE: cnt_q <= '0;
                endcase
            end
            if (wr_q) addr_q <= addr_step;
            if (adv_q) begin
                addr_q <= addr_step;
                rd_q   <= 1'b1;
            end
            if (pend_q) begin
                tx_q <= ld_byte;
            end else if ((state_q == ST_RD) && cs_act && sclk_fall) begin
                drv_q <= 1'b1;
                bit_q <= lsb_q ? tx_q[0] : tx_q[DATA_W-1];
                tx_q  <= lsb_q ? {1'b0, tx_q[DATA_W-1:1]} : {tx_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    // Outputs
    assign wr_stb   = wr_q;
    assign rd_stb   = rd_q;
    assign addr     = addr_q;
    assign wdata    = wdata_q;
    assign out_bit  = bit_q;
    assign drive    = drv_q;
    assign frame_w4 = w4_q;

    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |=> !wr_q); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q || adv_q) |=> (addr_q == ($past(asc_q) ? $past(addr_q) + ADDR_W'(1)
                                                     : $past(addr_q) - ADDR_W'(1)))); // R5

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (state_q == ST_IDLE) && !drv_q); // R10

    AST_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        drv_q |-> (state_q == ST_RD)); // R6

endmodule

// File: rtl/spi_stream_slave.sv
module spi_stream_slave
    import spi_stream_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              sdio_in_i,
    output logic              sdio_out_o,
    output logic              sdio_oe_o,
    output logic              sdo_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    output logic              soft_rst_o
);

    localparam logic [2:0] SYNC_RST = 3'b010; // {sclk, csn, sdi}

    logic [2:0]        pins_s;
    logic              sclk_s, csn_s, sdi_s, sclk_d_q;
    logic              sclk_rise, sclk_fall, cs_act;
    logic              wr_stb, rd_stb, out_bit, drive, frame_w4;
    logic              is_cfg, sel_cfg_q;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata, ld_byte;
    logic [7:0]        cfg_byte;
    logic              cfg_lsb, cfg_asc, cfg_w4, soft_rst;

    spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({sclk_i, csn_i, sdio_in_i}),
        .sync_o (pins_s)
    );

    assign sclk_s = pins_s[2];
    assign csn_s  = pins_s[1];
    assign sdi_s  = pins_s[0];
    assign cs_act = !csn_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d_q  <= 1'b0;
            sel_cfg_q <= 1'b0;
        end else begin
            sclk_d_q <= sclk_s;
            if (rd_stb) sel_cfg_q <= is_cfg;
        end
    end

    assign sclk_rise = sclk_s && !sclk_d_q;
    assign sclk_fall = !sclk_s && sclk_d_q;
    assign is_cfg    = (addr == ADDR_W'(CFG_ADDR));
    assign ld_byte   = sel_cfg_q ? DATA_W'(cfg_byte) : reg_rdata_i;

    spi_stream_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi       (sdi_s),
        .cfg_lsb   (cfg_lsb),
        .cfg_asc   (cfg_asc),
        .cfg_w4    (cfg_w4),
        .ld_byte   (ld_byte),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .addr      (addr),
        .wdata     (wdata),
        .out_bit   (out_bit),
        .drive     (drive),
        .frame_w4  (frame_w4)
    );

    spi_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_stb && is_cfg),
        .wdata     (wdata[7:0]),
        .cfg_byte  (cfg_byte),
        .lsb_first (cfg_lsb),
        .addr_asc  (cfg_asc),
        .wire4     (cfg_w4),
        .soft_rst  (soft_rst)
    );

    assign reg_wr_o    = wr_stb && !is_cfg;
    assign reg_rd_o    = rd_stb && !is_cfg;
    assign reg_addr_o  = addr;
    assign reg_wdata_o = wdata;
    assign soft_rst_o  = soft_rst;
    assign sdo_o       = frame_w4 && drive && out_bit;
    assign sdio_oe_o   = !frame_w4 && drive;
    assign sdio_out_o  = !frame_w4 && drive && out_bit;

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_o && reg_rd_o)); // R3

    AST_OE_NOT_4WIRE: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe_o |-> (sdo_o == 1'b0)); // R6

endmodule

// File: tb/tb_spi_stream_slave.sv
module tb_spi_stream_slave;

    localparam int HALF = 64; // ns, eight system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
    logic        sdio_out, sdio_oe, sdo, reg_wr, reg_rd, soft_rst;
    logic [14:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;

    int tests = 0, fails = 0;
    logic [7:0]  mem [64];
    logic [14:0] wlog_a [32];
    logic [7:0]  wlog_d [32];
    int          wn = 0, soft_cnt = 0;
    logic [7:0]  txb [8];
    logic [7:0]  rxb [8];
    bit          oe_hdr_bad, oe_dat_bad, sdo_bad;

    always #4 clk = ~clk; // 125 MHz

    spi_stream_slave dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdio_in_i(sdi),
        .sdio_out_o(sdio_out), .sdio_oe_o(sdio_oe), .sdo_o(sdo),
        .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_addr_o(reg_addr),
        .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata), .soft_rst_o(soft_rst)
    );

    // Register file model
    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr[5:0]] <= reg_wdata;
            wlog_a[wn % 32] <= reg_addr;
            wlog_d[wn % 32] <= reg_wdata;
            wn <= wn + 1;
        end
        if (reg_rd) reg_rdata <= mem[reg_addr[5:0]];
        if (soft_rst) soft_cnt <= soft_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One frame; extra_bits > 0 aborts after that many bits of the first data byte.
    task automatic xfer(input bit rd, input logic [14:0] a, input int n,
                        input bit lsb, input bit w4, input int extra_bits);
        logic pin;
        oe_hdr_bad = 0; oe_dat_bad = 0; sdo_bad = 0;
        @(negedge clk);
        csn = 1'b0;
        #(HALF);
        for (int k = 0; k < 16; k++) begin
            sdi = (k == 0) ? rd : (lsb ? a[k-1] : a[15-k]);
            #(HALF);
            if (sdio_oe) oe_hdr_bad = 1;
            sclk = 1'b1; #(HALF); sclk = 1'b0;
        end
        for (int b = 0; b < n; b++) begin
            logic [7:0] r = 8'h00;
            for (int j = 0; j < 8; j++) begin
                if (extra_bits > 0 && j == extra_bits) break;
                sdi = rd ? 1'b0 : (lsb ? txb[b][j] : txb[b][7-j]);
                #(HALF);
                pin = w4 ? sdo : sdio_out;
                if (rd && !w4 && !sdio_oe) oe_dat_bad = 1;
                if ((w4 && sdio_oe) || (!w4 && sdo)) sdo_bad = 1;
                r = lsb ? {pin, r[7:1]} : {r[6:0], pin};
                sclk = 1'b1; #(HALF); sclk = 1'b0;
            end
            rxb[b] = r;
        end
        #(HALF);
        csn = 1'b1;
        #(4*HALF);
    endtask

    task automatic t_reset;
        chk("R11 oe", sdio_oe, 0);
        chk("R11 sdo", sdo, 0);
        chk("R11 wr", reg_wr, 0);
        chk("R11 soft", soft_rst, 0);
        xfer(1, 15'h0, 1, 0, 0, 0);
        chk("R7 R11 cfg read at reset", rxb[0], 8'h00);
        chk("R6 oe in read data phase", oe_dat_bad, 0);
    endtask

    task automatic t_write_single;
        int w0 = wn;
        txb[0] = 8'hA5;
        xfer(0, 15'h0123, 1, 0, 0, 0);
        chk("R3 one strobe", wn - w0, 1);
        chk("R1 addr", wlog_a[w0 % 32], 15'h0123);
        chk("R1 data", wlog_d[w0 % 32], 8'hA5);
    endtask

    task automatic t_stream_desc;
        int w0 = wn;
        txb[0] = 8'h11; txb[1] = 8'h22; txb[2] = 8'h33;
        xfer(0, 15'h0022, 3, 0, 0, 0);
        chk("R4 count", wn - w0, 3);
        chk("R5 desc a1", wlog_a[(w0+1) % 32], 15'h0021);
        chk("R5 desc a2", wlog_a[(w0+2) % 32], 15'h0020);
        chk("R4 data2", wlog_d[(w0+2) % 32], 8'h33);
    endtask

    task automatic t_cfg_mirror;
        int w0 = wn;
        txb[0] = 8'h35; // asc + 4-wire, junk low nibble
        xfer(0, 15'h0, 1, 0, 0, 0);
        chk("R7 cfg write not on port", wn - w0, 0);
        xfer(1, 15'h0, 1, 0, 1, 0);
        chk("R8 mirror readback", rxb[0], 8'h3C);
    endtask

    task automatic t_stream_asc_read4;
        int w0 = wn;
        txb[0] = 8'h5A; txb[1] = 8'h6B; txb[2] = 8'h7C;
        xfer(0, 15'h003E, 3, 0, 1, 0);
        chk("R5 asc a1", wlog_a[(w0+1) % 32], 15'h003F);
        chk("R5 asc a2", wlog_a[(w0+2) % 32], 15'h0040);
        xfer(1, 15'h003E, 2, 0, 1, 0);
        chk("R6 4w read b0", rxb[0], 8'h5A);
        chk("R4 4w read b1", rxb[1], 8'h6B);
        chk("R6 4w oe quiet", sdo_bad, 0);
    endtask

    task automatic t_lsb_first;
        int w0;
        txb[0] = 8'h70; // lsb, asc, 4-wire
        xfer(0, 15'h0, 1, 0, 1, 0);
        xfer(1, 15'h0, 1, 1, 1, 0);
        chk("R2 R8 cfg lsb read", rxb[0], 8'h7E);
        w0 = wn;
        txb[0] = 8'hC3;
        xfer(0, 15'h0155, 1, 1, 1, 0);
        chk("R2 lsb addr", wlog_a[w0 % 32], 15'h0155);
        chk("R2 lsb data", wlog_d[w0 % 32], 8'hC3);
        txb[0] = 8'h00;
        xfer(1, 15'h0121, 1, 1, 1, 0);
        mem[6'h21] = mem[6'h21];
        chk("R2 lsb read", rxb[0], mem[6'h21]);
    endtask

    task automatic t_three_wire;
        txb[0] = 8'h20; // asc, 3-wire, msb (frame itself still lsb)
        xfer(0, 15'h0, 1, 1, 1, 0);
        xfer(1, 15'h0020, 2, 0, 0, 0);
        chk("R6 3w b0", rxb[0], 8'h33);
        chk("R6 3w b1", rxb[1], 8'h22);
        chk("R6 oe low in header", oe_hdr_bad, 0);
        chk("R6 oe high in data", oe_dat_bad, 0);
        chk("R6 sdo idle in 3w", sdo_bad, 0);
        chk("R6 oe released", sdio_oe, 0);
    endtask

    task automatic t_abort;
        int w0 = wn;
        txb[0] = 8'hFF;
        xfer(0, 15'h0030, 1, 0, 0, 5);
        chk("R10 no write", wn - w0, 0);
        chk("R10 oe low", sdio_oe, 0);
        txb[0] = 8'h44;
        xfer(0, 15'h0031, 1, 0, 0, 0);
        chk("R10 next frame clean", wlog_a[w0 % 32], 15'h0031);
    endtask

    task automatic t_soft_reset;
        int s0 = soft_cnt;
        txb[0] = 8'hA0;
        xfer(0, 15'h0, 1, 0, 0, 0);
        chk("R9 one pulse", soft_cnt - s0, 1);
        xfer(1, 15'h0, 1, 0, 0, 0);
        chk("R9 cfg cleared", rxb[0], 8'h00);
    endtask

    initial begin
        #(2_000_000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        reg_rdata = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_single();
        t_stream_desc();
        t_cfg_mirror();
        t_stream_asc_read4();
        t_lsb_first();
        t_three_wire();
        t_abort();
        t_soft_reset();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule